// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one timer channel. It counts ticks and drives a single output line, `out`, whose waveform follows one of six operating modes. A count of 1 to 65535 is written through the load port together with a 3-bit mode. A written count of zero stands for 65536. From then on, every clock on which `tick_en` is high counts as a tick. `out` and the readable value `count_value` both depend only on the mode, the loaded count N and the number of ticks d that have elapsed since the last load or retrigger.

The `gate` input acts in one of two ways, chosen by the mode. In the single-shot and software strobe modes it pauses counting while it is low. In the hardware-triggered and periodic modes, a rising edge on it restarts counting from N. A one-clock pulse on `out_rise_irq` marks every rising edge of `out`, so the channel can feed an interrupt controller directly.

The control is a four-state machine:

| State | Meaning |
|---|---|
| IDLE | Held from reset until the first load. |
| COUNT | Entered on every load and retrigger. |
| EXPIRED | Entered from COUNT in the single-shot modes when d reaches N. |
| PERIODIC | Entered from COUNT in the periodic modes when the first period completes. |

EXPIRED and PERIODIC are left only by a load or a retrigger.

Top module: `interval_counter`

## Requirements
- R1: After reset `out`, `out_rise_irq` and `count_value` are 0. Before the first load, ticks and gate edges change none of them.
- R2: A loaded count of 0 is treated as N = 65536. `count_value` reads 0 right after that load. Mode 0 raises `out` after exactly 65536 ticks.
- R3: Mode 0 (`load_mode`=0): `out` is low after the load, goes high on the tick where d reaches N, and stays high until the next load.
- R4: Mode 1: `out` is low while d < N and high once d >= N. A gate rising edge sets d back to 0.
- R5: Mode 2: `out` is high except while d is a nonzero multiple of N, when it is low for that one tick.
- R6: Mode 3: `out` is high while (d mod N) < (N+1)/2 and low otherwise. `count_value` = (N - (2d mod N)) mod 65536.
- R7: In modes 0, 1, 4 and 5, `count_value` = (N - d) mod 65536. In mode 2 it is (N - (d mod N)) mod 65536. A load or retrigger sets d to 0, and a tick on the clock of a load or retrigger is not counted.
- R8: In modes 0 and 4, ticks are not counted while `gate` is low, so `count_value` holds.
- R9: In modes 1, 2, 3 and 5, a rising edge on `gate` restarts counting at d = 0. In modes 0 and 4 a rising edge does not restart counting.
- R10: `out_rise_irq` is high for exactly the one clock on which `out` has just risen, and low otherwise.
- R11: Mode values 6 and 7 behave exactly as modes 2 and 3.
- R12: Modes 4 and 5: `out` is high only while d equals N. Mode 5 fires again after each gate retrigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting tick qualifier |
| gate | input | 1 | Gate level; pauses or retriggers, depending on the mode |
| load_en | input | 1 | Load the new count and mode this clock |
| load_value | input | CNT_W | Initial count (0 means 65536) |
| load_mode | input | 3 | Operating mode 0..7 |
| count_value | output | CNT_W | Live readable count |
| out | output | 1 | Timer output line |
| out_rise_irq | output | 1 | One-clock pulse on each rise of `out` |

## Verification
The hardest corner to reach is a zero load with its 65536-tick expiry. The stimulus reaches it with one uninterrupted run of more than 65536 ticks in mode 0, and checks `count_value` and `out` across the wrap. Square wave mode with odd N and with N = 1 also needs care, because the count steps by two and wraps modulo N. The bench loads N = 5, 4 and 1 and drives tick patterns with gaps, so the wrap falls on different cycles. Gate edges are placed on chosen cycles: during a pause, after expiry and mid-period. This shows whether a given rising edge restarts counting or merely resumes it.

// File: rtl/interval_counter_pkg.sv
`timescale 1ns/1ps
package interval_counter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_EXPIRED,
        ST_PERIODIC
    } chan_state_e;

    typedef enum logic [2:0] {
        MD_TERMINAL     = 3'd0,
        MD_ONESHOT      = 3'd1,
        MD_RATE         = 3'd2,
        MD_SQUARE       = 3'd3,
        MD_SOFT_STROBE  = 3'd4,
        MD_GATED_STROBE = 3'd5
    } chan_mode_e;

endpackage

// File: rtl/ic_mode_decode.sv
`timescale 1ns/1ps
module ic_mode_decode
    import interval_counter_pkg::*;
(
    input  logic [2:0]  mode_raw,
    output chan_mode_e  mode_eff,
    output logic        oneshot,
    output logic        gate_pauses,
    output logic        gate_restarts
);

    // Codes 6 and 7 fold onto the two periodic modes.
    always_comb begin
        mode_eff = chan_mode_e'(mode_raw[1] ? {1'b0, mode_raw[1:0]} : mode_raw);
    end

    always_comb begin
        oneshot       = 1'b1;
        gate_pauses   = 1'b0;
        gate_restarts = 1'b1;
        case (mode_eff)
            MD_TERMINAL:     begin gate_pauses = 1'b1; gate_restarts = 1'b0; end
            MD_SOFT_STROBE:  begin gate_pauses = 1'b1; gate_restarts = 1'b0; end
            MD_RATE:         oneshot = 1'b0;
            MD_SQUARE:       oneshot = 1'b0;
            default:         ;
        endcase
    end

endmodule

// File: rtl/ic_phase_fsm.sv
`timescale 1ns/1ps
module ic_phase_fsm
    import interval_counter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic              oneshot,
    input  logic [CNT_W:0]    n_period,
    output chan_state_e       state,
    output logic [CNT_W:0]    elapsed
);

    localparam int FULL_W = CNT_W + 1;
    localparam logic [FULL_W-1:0] EL_MAX = '1;

    chan_state_e       state_d;
    logic [FULL_W-1:0] el_d;
    logic [FULL_W-1:0] el_inc;

    assign el_inc = elapsed + FULL_W'(1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            elapsed <= '0;
        end else begin
            state   <= state_d;
            elapsed <= el_d;
        end
    end

    // Next state and elapsed-tick tracking
    always_comb begin
        state_d = state;
        el_d    = elapsed;
        if (restart) begin
            state_d = ST_COUNT;
            el_d    = '0;
        end else if (step) begin
            unique case (state)
                ST_IDLE: ;
                ST_COUNT: begin
                    if (oneshot) begin
                        el_d = el_inc;
                        if (el_inc == n_period) state_d = ST_EXPIRED;
                    end else if (el_inc == n_period) begin
                        el_d    = '0;
                        state_d = ST_PERIODIC;
                    end else begin
                        el_d = el_inc;
                    end
                end
                ST_EXPIRED: begin
                    el_d = (elapsed == EL_MAX) ? elapsed : el_inc;
                end
                ST_PERIODIC: begin
                    el_d = (el_inc == n_period) ? '0 : el_inc;
                end
            endcase
        end
    end

    AST_PHASE_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!oneshot && state != ST_IDLE) |-> (elapsed < n_period)); // R5

    AST_EXPIRED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXPIRED && !restart) |=> (state == ST_EXPIRED)); // R3

endmodule

// File: rtl/ic_readback.sv
`timescale 1ns/1ps
module ic_readback
    import interval_counter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic              active,
    input  chan_mode_e        mode_eff,
    input  logic [CNT_W:0]    n_start,
    input  logic [CNT_W:0]    n_period,
    output logic [CNT_W-1:0]  count
);

    localparam int FULL_W = CNT_W + 1;

    logic [FULL_W-1:0] rd_q;
    logic [FULL_W-1:0] rd_d;
    logic [FULL_W-1:0] dec1;

    assign dec1  = rd_q - FULL_W'(1);
    assign count = rd_q[CNT_W-1:0];

    always_comb begin
        rd_d = rd_q;
        if (restart) begin
            rd_d = n_start;
        end else if (step) begin
            case (mode_eff)
                MD_RATE:   rd_d = (rd_q == FULL_W'(1)) ? n_period : dec1;
                MD_SQUARE: begin
                    if (n_period == FULL_W'(1))
                        rd_d = rd_q;
                    else if (rd_q > FULL_W'(2))
                        rd_d = rd_q - FULL_W'(2);
                    else
                        rd_d = rd_q + n_period - FULL_W'(2);
                end
                default:   rd_d = {1'b0, dec1[CNT_W-1:0]};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    AST_PERIODIC_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (mode_eff == MD_RATE || mode_eff == MD_SQUARE))
            |-> (rd_q != '0 && rd_q <= n_period)); // R7

endmodule

// File: rtl/interval_counter.sv
`timescale 1ns/1ps
module interval_counter
    import interval_counter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              gate,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_value,
    input  logic [2:0]        load_mode,
    output logic [CNT_W-1:0]  count_value,
    output logic              out,
    output logic              out_rise_irq
);

    localparam int FULL_W = CNT_W + 1;
    localparam logic [FULL_W-1:0] ZERO_SUB = FULL_W'(1) << CNT_W;

    logic [FULL_W-1:0] n_q;
    logic [FULL_W-1:0] n_new;
    logic [FULL_W-1:0] n_start;
    logic [FULL_W-1:0] half_w;
    logic [FULL_W-1:0] elapsed;
    logic [2:0]        mode_q;
    logic              gate_d;
    logic              out_d;
    chan_mode_e        mode_eff;
    chan_state_e       state;
    logic              oneshot, gate_pauses, gate_restarts;
    logic              loaded, gate_rise, retrig, restart, step;

    assign n_new     = (load_value == '0) ? ZERO_SUB : {1'b0, load_value};
    assign n_start   = load_en ? n_new : n_q;
    assign half_w    = (n_q + FULL_W'(1)) >> 1;
    assign loaded    = (state != ST_IDLE);
    assign gate_rise = gate & ~gate_d;
    assign retrig    = !load_en && loaded && gate_rise && gate_restarts;
    assign restart   = load_en | retrig;
    assign step      = !restart && loaded && tick_en && (gate || !gate_pauses);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            mode_q <= '0;
            gate_d <= 1'b0;
            out_d  <= 1'b0;
        end else begin
            gate_d <= gate;
            out_d  <= out;
            if (load_en) begin
                n_q    <= n_new;
                mode_q <= load_mode;
            end
        end
    end

    ic_mode_decode u_decode (
        .mode_raw      (mode_q),
        .mode_eff      (mode_eff),
        .oneshot       (oneshot),
        .gate_pauses   (gate_pauses),
        .gate_restarts (gate_restarts)
    );

    ic_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .step     (step),
        .oneshot  (oneshot),
        .n_period (n_q),
        .state    (state),
        .elapsed  (elapsed)
    );

    ic_readback #(.CNT_W(CNT_W)) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .step     (step),
        .active   (loaded),
        .mode_eff (mode_eff),
        .n_start  (n_start),
        .n_period (n_q),
        .count    (count_value)
    );

    // Output decode per state and mode
    always_comb begin
        out = 1'b0;
        unique case (state)
            ST_IDLE:  out = 1'b0;
            ST_COUNT: begin
                case (mode_eff)
                    MD_RATE:   out = 1'b1;
                    MD_SQUARE: out = (elapsed < half_w);
                    default:   out = 1'b0;
                endcase
            end
            ST_EXPIRED: begin
                case (mode_eff)
                    MD_TERMINAL, MD_ONESHOT:         out = 1'b1;
                    MD_SOFT_STROBE, MD_GATED_STROBE: out = (elapsed == n_q);
                    default:                         out = 1'b0;
                endcase
            end
            ST_PERIODIC: begin
                case (mode_eff)
                    MD_RATE:   out = (elapsed != '0);
                    MD_SQUARE: out = (elapsed < half_w);
                    default:   out = 1'b0;
                endcase
            end
        endcase
    end

    assign out_rise_irq = out & ~out_d;

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_rise_irq |=> !out_rise_irq); // R10

    AST_PAUSE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && gate_pauses && !gate && !load_en) |=> $stable(count_value)); // R8

endmodule

// File: tb/interval_counter_tb.sv
`timescale 1ns/1ps
module interval_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en, gate, load_en;
    logic [15:0] load_value;
    logic [2:0]  load_mode;
    logic [15:0] count_value;
    logic        out, out_rise_irq;

    always #5 clk = ~clk;

    interval_counter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .gate         (gate),
        .load_en      (load_en),
        .load_value   (load_value),
        .load_mode    (load_mode),
        .count_value  (count_value),
        .out          (out),
        .out_rise_irq (out_rise_irq)
    );

    int     n_checks = 0;
    int     n_fail   = 0;
    string  cur_req  = "R1";
    bit     done     = 1'b0;

    // Reference model state
    longint m_n      = 1;
    int     m_mode   = 0;
    bit     m_loaded = 1'b0;
    longint m_d      = 0;
    bit     m_gprev  = 1'b0;
    bit     m_oprev  = 1'b0;

    function automatic int fold(input int m);
        return (m >= 6) ? m - 4 : m;
    endfunction

    function automatic bit exp_out();
        if (!m_loaded) return 1'b0;
        case (m_mode)
            0, 1:    return m_d >= m_n;
            2:       return !((m_d % m_n == 0) && m_d != 0);
            3:       return (m_d % m_n) < ((m_n + 1) / 2);
            default: return m_d == m_n;
        endcase
    endfunction

    function automatic longint exp_cnt();
        if (!m_loaded) return 0;
        case (m_mode)
            2:       return (m_n - (m_d % m_n)) % 65536;
            3:       return (m_n - ((2 * m_d) % m_n)) % 65536;
            default: return (((m_n - m_d) % 65536) + 65536) % 65536;
        endcase
    endfunction

    task automatic check(input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic cyc(input bit t, input bit g, input bit ld, input int val, input int md);
        bit eo;
        tick_en    = t;
        gate       = g;
        load_en    = ld;
        load_value = val[15:0];
        load_mode  = md[2:0];
        @(posedge clk);
        if (ld) begin
            m_n      = (val == 0) ? 65536 : val;
            m_mode   = fold(md);
            m_d      = 0;
            m_loaded = 1'b1;
        end else if (m_loaded && g && !m_gprev && (m_mode inside {1, 2, 3, 5})) begin
            m_d = 0;
        end else if (m_loaded && t && (g || !(m_mode inside {0, 4}))) begin
            m_d++;
        end
        m_gprev = g;
        #1;
        eo = exp_out();
        check("count_value", count_value, exp_cnt());
        check("out", out, eo);
        check("out_rise_irq (R10)", out_rise_irq, eo && !m_oprev);
        m_oprev = eo;
    endtask

    task automatic run(input int k, input bit g, input bit gappy);
        for (int i = 0; i < k; i++) cyc(gappy ? (i % 3 != 2) : 1'b1, g, 1'b0, 0, 0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; gate = 1'b0; load_en = 1'b0;
        load_value = '0; load_mode = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";
        check("count_value", count_value, 0);
        check("out", out, 0);
        check("out_rise_irq", out_rise_irq, 0);
        cyc(1, 1, 0, 0, 0); cyc(1, 0, 0, 0, 0); cyc(1, 1, 0, 0, 0);

        cur_req = "R3";
        cyc(1, 1, 1, 5, 0); run(8, 1, 0);

        cur_req = "R8";
        cyc(1, 1, 1, 6, 0); run(2, 1, 0); run(3, 0, 0);
        cur_req = "R9";
        run(6, 1, 1);

        cur_req = "R4";
        cyc(1, 1, 1, 4, 1); run(6, 1, 0); run(2, 0, 0); run(2, 1, 0);
        run(1, 0, 0); run(7, 1, 0);

        cur_req = "R12";
        cyc(1, 1, 1, 3, 4); run(2, 1, 0); run(2, 0, 0); run(5, 1, 0);
        cyc(1, 1, 1, 3, 5); run(5, 1, 0); run(1, 0, 0); run(5, 1, 0);

        cur_req = "R5/R7";
        cyc(1, 1, 1, 4, 2); run(12, 1, 1); run(1, 0, 0); run(9, 1, 0);
        cyc(1, 1, 1, 1, 2); run(4, 1, 0);

        cur_req = "R6";
        cyc(1, 1, 1, 5, 3); run(12, 1, 0); run(1, 0, 0); run(8, 1, 1);
        cyc(1, 1, 1, 4, 3); run(10, 1, 0);
        cyc(1, 1, 1, 1, 3); run(3, 1, 0);

        cur_req = "R11";
        cyc(1, 1, 1, 3, 6); run(7, 1, 0);
        cyc(1, 1, 1, 6, 7); run(8, 1, 1);

        cur_req = "R2";
        cyc(1, 1, 1, 0, 3); run(3, 1, 0);
        cyc(1, 1, 1, 0, 0); run(65540, 1, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule